// File: doc/BRIEF.md
# Low-Power Periodic Wake Timer

This block is a free-running interval timer. It keeps counting while the processor sleeps and sends a periodic wake or interrupt request. It is built from a 7-bit prescaler and a 14-bit binary count chain. The prescaler divides the main clock by 128. With a 4.194304 MHz main clock, this gives a 32.768 kHz count rate. One tap of the count chain is chosen as the wake interval: 2 Hz, 4 Hz or 16 Hz. Each time the chosen tap rises, the block emits a one-cycle interrupt pulse that is synchronous to the system clock. The whole count vector is also brought out, so that neighbouring timers can use its bits as slow clock enables.

Software controls the block through a 5-bit read/write control word. The word selects the count source and the interval, and it holds an enable bit. A factory test source feeds the undivided main clock straight into the chain. The prescaler is a clock-enable generator, not a derived clock, so the whole block sits in one clock domain. When the main clock halts in stop mode, the count simply freezes.

Top module: `wake_tmr`

## Requirements
- R1: A synchronous active-high reset clears the control word, the prescaler and the count chain, and holds the interrupt output low. The timer therefore comes out of reset disabled, with `tap_o` = 0.
- R2: The control word is laid out as bit 4 = enable, bits 3:2 = interval code and bits 1:0 = source code. A write stores all 5 bits, and `ctl_rdata` returns them from the cycle after the write.
- R3: Source codes 00 and 11 supply no count, even when the enable bit is 1, and `tap_o` holds its value.
- R4: Source code 10 (test path) advances `tap_o` by one on every clock edge while the timer is enabled.
- R5: Source code 01 advances `tap_o` by one once every 128 clock edges while the timer is enabled. The prescaler starts from zero after reset.
- R6: Clearing the enable bit freezes `tap_o` and the prescaler without clearing them. Setting it again resumes counting from the held value.
- R7: Interval code 00 pulses `wake_irq` whenever bit 13 of the count rises, which is once per 16384 counts (2 Hz).
- R8: Interval code 01 pulses `wake_irq` whenever bit 12 rises, which is once per 8192 counts (4 Hz).
- R9: Interval code 10 pulses `wake_irq` whenever bit 10 rises, which is once per 2048 counts (16 Hz).
- R10: Interval code 11 behaves exactly like code 00.
- R11: `wake_irq` is high for exactly one clock cycle per event. It goes high in the same cycle that `tap_o` first shows the selected bit set.
- R12: The count wraps from 16383 to 0 and continues. The wrap itself raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 5 | Control word write data |
| ctl_rdata | output | 5 | Control word readback |
| tap_o | output | 14 | Count chain value, used as tap vector |
| wake_irq | output | 1 | One-cycle wake interrupt pulse |

## Verification
The bench runs the test source through more than a full wrap of the 14-bit count for every interval code. Across each run, every edge and every bit of the count is compared, so a design with a wrong tap would pulse at the wrong period, and a design that fires on falling edges or on the wrap would pulse half a period off. The prescaled path is checked over many 128-cycle windows, which exposes an off-by-one divisor. The bench also toggles the enable bit in the middle of a run to catch a design that clears the count instead of freezing it. Finally, it sets both idle source codes with the enable bit on, to catch a design that counts on the reserved code.

// File: rtl/wake_tmr_pkg.sv
package wake_tmr_pkg;

    typedef enum logic [1:0] {
        SRC_OFF  = 2'b00,
        SRC_DIV  = 2'b01,
        SRC_FAST = 2'b10,
        SRC_RSV  = 2'b11
    } src_e;

    typedef enum logic [1:0] {
        IVL_SLOW = 2'b00,
        IVL_MID  = 2'b01,
        IVL_FAST = 2'b10,
        IVL_ALT  = 2'b11
    } ivl_e;

    typedef struct packed {
        logic en;
        ivl_e ivl;
        src_e src;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    function automatic logic uses_prescaler(ctl_t c);
        return c.en && (c.src == SRC_DIV);
    endfunction

    function automatic logic uses_fast(ctl_t c);
        return c.en && (c.src == SRC_FAST);
    endfunction

endpackage

// File: rtl/wt_ctl_reg.sv
module wt_ctl_reg
    import wake_tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CTL_W-1:0] wdata,
    output ctl_t             ctl
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else if (wr) begin
            ctl <= ctl_t'(wdata);
        end
    end

    // R2
    ctl_store_chk: assert property (@(posedge clk) disable iff (rst)
        wr |=> (ctl == $past(wdata)));

endmodule

// File: rtl/wt_prescale.sv
module wt_prescale #(
    parameter int PRE_W = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);

    logic [PRE_W-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
        end else if (run) begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assign tick = run && (&pre_q);

    // R5
    tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    // R6
    pre_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(pre_q));

endmodule

// File: rtl/wt_chain.sv
module wt_chain
    import wake_tmr_pkg::*;
#(
    parameter int CNT_W    = 14,
    parameter int TAP_SLOW = 13,
    parameter int TAP_MID  = 12,
    parameter int TAP_FAST = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  ivl_e             ivl,
    output logic [CNT_W-1:0] cnt,
    output logic             irq
);

    localparam int IDX_W = $clog2(CNT_W);

    logic [CNT_W-1:0] cnt_nxt;
    logic [IDX_W-1:0] sel;

    always_comb begin
        unique case (ivl)
            IVL_MID:  sel = IDX_W'(TAP_MID);
            IVL_FAST: sel = IDX_W'(TAP_FAST);
            default:  sel = IDX_W'(TAP_SLOW);
        endcase
    end

    assign cnt_nxt = cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            irq <= 1'b0;
        end else begin
            if (step) begin
                cnt <= cnt_nxt;
            end
            irq <= step && !cnt[sel] && cnt_nxt[sel];
        end
    end

    // R11
    irq_single_chk: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R6
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(cnt));

    // R12
    wrap_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (step && (&cnt)) |=> (!irq && cnt == '0));

endmodule

// File: rtl/wake_tmr.sv
module wake_tmr
    import wake_tmr_pkg::*;
#(
    parameter int CNT_W    = 14,
    parameter int PRE_W    = 7,
    parameter int TAP_SLOW = 13,
    parameter int TAP_MID  = 12,
    parameter int TAP_FAST = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic [CTL_W-1:0] ctl_rdata,
    output logic [CNT_W-1:0] tap_o,
    output logic             wake_irq
);

    ctl_t ctl;
    logic pre_run;
    logic pre_tick;
    logic step;

    wt_ctl_reg u_ctl (
        .clk   (clk),
        .rst   (rst),
        .wr    (ctl_wr),
        .wdata (ctl_wdata),
        .ctl   (ctl)
    );

    assign pre_run = uses_prescaler(ctl);

    wt_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (pre_run),
        .tick (pre_tick)
    );

    assign step = uses_fast(ctl) || pre_tick;

    wt_chain #(
        .CNT_W    (CNT_W),
        .TAP_SLOW (TAP_SLOW),
        .TAP_MID  (TAP_MID),
        .TAP_FAST (TAP_FAST)
    ) u_chain (
        .clk  (clk),
        .rst  (rst),
        .step (step),
        .ivl  (ctl.ivl),
        .cnt  (tap_o),
        .irq  (wake_irq)
    );

    assign ctl_rdata = ctl;

    // R3
    idle_src_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.src == SRC_OFF || ctl.src == SRC_RSV) |=> $stable(tap_o));

    // R4
    fast_step_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.en && ctl.src == SRC_FAST) |=> (tap_o == $past(tap_o) + 1'b1));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (tap_o == '0 && !wake_irq && ctl_rdata == '0));

endmodule

// File: tb/wake_tmr_test.sv
module wake_tmr_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_wr = 1'b0;
    logic [4:0]  ctl_wdata = '0;
    logic [4:0]  ctl_rdata;
    logic [13:0] tap_o;
    logic        wake_irq;

    int n_cmp = 0;
    int n_bad = 0;
    int pulses = 0;

    int m_cnt = 0, m_pre = 0, m_en = 0, m_ivl = 0, m_src = 0;
    int e_irq = 0;
    string t_tag, i_tag;

    always #4 clk = ~clk;

    wake_tmr uut (
        .clk       (clk),
        .rst       (rst),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_wdata),
        .ctl_rdata (ctl_rdata),
        .tap_o     (tap_o),
        .wake_irq  (wake_irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input logic wr, input logic [4:0] data);
        int step, b, nc;
        ctl_wr    = wr;
        ctl_wdata = data;
        @(posedge clk);
        if (rst) begin
            m_cnt = 0; m_pre = 0; m_en = 0; m_ivl = 0; m_src = 0; e_irq = 0;
            t_tag = "R1"; i_tag = "R1";
        end else begin
            step = 0;
            if (m_en == 1 && m_src == 2) step = 1;
            if (m_en == 1 && m_src == 1) begin
                if (m_pre == 127) step = 1;
                m_pre = (m_pre + 1) % 128;
            end
            b  = (m_ivl == 1) ? 12 : (m_ivl == 2) ? 10 : 13;
            nc = (m_cnt + step) % 16384;
            e_irq = (step == 1 && ((nc >> b) & 1) == 1 && ((m_cnt >> b) & 1) == 0) ? 1 : 0;
            if (m_en == 0) t_tag = "R6";
            else if (m_src == 2) t_tag = (nc == 0) ? "R12" : "R4";
            else if (m_src == 1) t_tag = "R5";
            else t_tag = "R3";
            case (m_ivl)
                0: i_tag = "R7";
                1: i_tag = "R8";
                2: i_tag = "R9";
                default: i_tag = "R10";
            endcase
            m_cnt = nc;
            if (wr) begin
                m_en  = data[4];
                m_ivl = data[3:2];
                m_src = data[1:0];
            end
        end
        @(negedge clk);
        ctl_wr = 1'b0;
        check(t_tag, tap_o, m_cnt);
        check(i_tag, wake_irq, e_irq);
        check("R2", ctl_rdata, {m_en[0], m_ivl[1:0], m_src[1:0]});
        if (wake_irq) pulses++;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 5'd0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        run(3);
        rst = 1'b0;
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int expp, b, n;
        @(negedge clk);
        do_reset();
        // R1: reset state
        check("R1", tap_o, 0);
        check("R1", wake_irq, 0);
        check("R1", ctl_rdata, 0);

        // R2: every control word value read back
        for (int v = 0; v < 32; v++) cyc(1'b1, v[4:0]);

        // R7 R8 R9 R10 R11 R12: per interval code, past a full wrap on the test path
        for (int k = 0; k < 4; k++) begin
            do_reset();
            cyc(1'b1, {1'b1, k[1:0], 2'b10});
            pulses = 0;
            n = 16384 + 2500;
            run(n);
            b = (k == 1) ? 12 : (k == 2) ? 10 : 13;
            expp = 0;
            for (int c = 1; c <= n; c++)
                if ((c % (2 << b)) == (1 << b)) expp++;
            check("R11", pulses, expp);
        end

        // R5: prescaled source, one count per 128 edges
        do_reset();
        cyc(1'b1, 5'b1_10_01);
        run(128 * 20);
        check("R5", tap_o, 20);

        // R3: idle source codes with the enable bit set
        cyc(1'b1, 5'b1_00_00);
        run(300);
        cyc(1'b1, 5'b1_01_11);
        run(300);
        check("R3", tap_o, 20);

        // R6: hold and resume, on both sources
        cyc(1'b1, 5'b1_00_10);
        run(500);
        cyc(1'b1, 5'b0_00_10);
        run(200);
        check("R6", tap_o, 521);
        cyc(1'b1, 5'b1_00_10);
        run(100);
        cyc(1'b1, 5'b1_00_01);
        run(70);
        cyc(1'b1, 5'b0_00_01);
        run(300);
        cyc(1'b1, 5'b1_00_01);
        run(200);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule